// File: doc/BRIEF.md
# Prioritized Multi-Level Interrupt Pending Tracker

This block tracks pending interrupt requests from a set of numbered sources. Each source is assigned one priority level, one trigger mode and one vector index through a configuration write port. Request ports set a source's pending bit or clear it. From that state the block derives a bitmap of the sources waiting at each level and a summary mask of the levels that have any such source. It also keeps a registered highest-pending level, which holds an all-ones value when nothing waits.

The processor side compares that registered level against its own current level, so it learns in the same cycle whether an interrupt can be taken. A claim takes the best waiting source and returns it one cycle later. Edge-mode sources lose their pending bit when claimed. Level-mode sources keep the pending bit, are marked in service, and are ignored until an end-of-service pulse names them again.

Top module: `prio_irq_tracker`

## Requirements
- R1: After reset, hp_lvl_o is 8'hFF, lvl_mask_o is 0, deliver_o is 0 and claim_vld_o is 0.
- R2: A source is eligible when it is pending and not in service. One cycle after a raise of source S, bit L of lvl_mask_o is set, where L is S's configured level. hp_lvl_o then equals the highest level that has an eligible source, or 8'hFF if there is none.
- R3: deliver_o is 1 exactly when hp_lvl_o is not 8'hFF and hp_lvl_o is strictly greater than cpu_lvl_i. It follows cpu_lvl_i in the same cycle.
- R4: One cycle after a clear of source S, S is no longer pending. A level's bit in lvl_mask_o drops when no eligible source remains at that level, and hp_lvl_o is recomputed.
- R5: When a raise and a clear name the same source in the same cycle, the clear wins and the source is not pending afterwards.
- R6: When claim_i is 1 and deliver_o is 1, claim_vld_o is 1 in the next cycle. That cycle also shows the source, its level and its vector on claim_src_o, claim_lvl_o and claim_vec_o. The source is taken from the highest eligible level, and within that level the lowest-numbered eligible source wins.
- R7: Claiming an edge-mode source clears its pending bit.
- R8: Claiming a level-mode source keeps it pending but marks it in service. While in service it counts toward neither lvl_mask_o, hp_lvl_o nor deliver_o.
- R9: An eos_vld_i pulse naming a source removes its in-service mark one cycle later. If that source is still pending, it is eligible again.
- R10: A claim while deliver_o is 0 gives claim_vld_o = 0 in the next cycle and changes neither pending nor in-service state.
- R11: A cfg_we_i write stores cfg_lvl_i as the level, cfg_vec_i as the vector and cfg_lvl_mode_i as the trigger mode of source cfg_src_i. Mode value 1 means level mode and 0 means edge mode. Changing the level of a pending source moves it to the new level in lvl_mask_o and hp_lvl_o one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_vld_i | input | 1 | Raise request strobe |
| raise_src_i | input | SRC_W | Source to mark pending |
| clr_vld_i | input | 1 | Clear request strobe |
| clr_src_i | input | SRC_W | Source to drop |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_src_i | input | SRC_W | Source being configured |
| cfg_lvl_mode_i | input | 1 | Trigger mode, 1 = level, 0 = edge |
| cfg_lvl_i | input | LVL_W | Priority level for the source |
| cfg_vec_i | input | VEC_W | Vector index for the source |
| eos_vld_i | input | 1 | End-of-service strobe |
| eos_src_i | input | SRC_W | Source leaving service |
| cpu_lvl_i | input | 8 | Current processor priority level |
| claim_i | input | 1 | Claim request |
| deliver_o | output | 1 | An eligible level exceeds cpu_lvl_i |
| hp_lvl_o | output | 8 | Highest eligible level, 8'hFF when none |
| lvl_mask_o | output | NUM_LVL | Per-level summary of eligible sources |
| claim_vld_o | output | 1 | Claim response valid |
| claim_src_o | output | SRC_W | Claimed source |
| claim_lvl_o | output | 8 | Level of claimed source |
| claim_vec_o | output | VEC_W | Vector of claimed source |

## Verification
The assertions need no limits on the inputs beyond the source numbers fitting in SRC_W and the level field staying below NUM_LVL. Under those limits the sentinel and summary mask must agree, and a granted claim must answer with the level that was highest when it was issued, above the processor level given then. The bench writes only levels below NUM_LVL. It pulses end of service only for sources it knows are in service, and it changes cpu_lvl_i only between clock edges. As a result, every claim is judged against a threshold that is stable at the clock edge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  localparam logic [7:0] LVL_NONE = 8'hFF;
endpackage

// File: rtl/prio_irq_cfg.sv
module prio_irq_cfg #(
  parameter int NUM_SRC = 32,
  parameter int LVL_W   = 4,
  parameter int VEC_W   = 8,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we_i,
  input  logic [SRC_W-1:0]                src_i,
  input  logic                            lvl_mode_i,
  input  logic [LVL_W-1:0]                lvl_i,
  input  logic [VEC_W-1:0]                vec_i,
  output logic [NUM_SRC-1:0]              mode_q,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_q,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_d,
  output logic [NUM_SRC-1:0][VEC_W-1:0]   vec_q
);
  logic [NUM_SRC-1:0]            mode_d;
  logic [NUM_SRC-1:0][VEC_W-1:0] vec_d;

  always_comb begin
    mode_d = mode_q;
    lvl_d  = lvl_q;
    vec_d  = vec_q;
    if (we_i) begin
      mode_d[src_i] = lvl_mode_i;
      lvl_d[src_i]  = lvl_i;
      vec_d[src_i]  = vec_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      lvl_q  <= '0;
      vec_q  <= '0;
    end else if (we_i) begin
      mode_q <= mode_d;
      lvl_q  <= lvl_d;
      vec_q  <= vec_d;
    end
  end
endmodule

// File: rtl/prio_irq_summary.sv
module prio_irq_summary #(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 16,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic [NUM_SRC-1:0]            elig_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic [NUM_LVL-1:0]            mask_o,
  output logic [7:0]                    top_o
);
  import prio_irq_pkg::*;

  logic [NUM_LVL-1:0][NUM_SRC-1:0] lvl_map;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign lvl_map[l][s] = elig_i[s] && (lvl_i[s] == LVL_W'(l));
    end
    assign mask_o[l] = |lvl_map[l];
  end

  always_comb begin
    top_o = LVL_NONE;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (mask_o[l]) top_o = 8'(l);
    end
  end
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
  parameter int NUM_SRC = 32,
  parameter int LVL_W   = 4,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]            elig_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0]              sel_lvl_i,
  output logic                          found_o,
  output logic [SRC_W-1:0]              idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (elig_i[s] && (lvl_i[s] == sel_lvl_i)) begin
        found_o = 1'b1;
        idx_o   = SRC_W'(s);
      end
    end
  end
endmodule

// File: rtl/prio_irq_tracker.sv
module prio_irq_tracker #(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 16,
  parameter int VEC_W   = 8,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raise_vld_i,
  input  logic [SRC_W-1:0]   raise_src_i,
  input  logic               clr_vld_i,
  input  logic [SRC_W-1:0]   clr_src_i,
  input  logic               cfg_we_i,
  input  logic [SRC_W-1:0]   cfg_src_i,
  input  logic               cfg_lvl_mode_i,
  input  logic [LVL_W-1:0]   cfg_lvl_i,
  input  logic [VEC_W-1:0]   cfg_vec_i,
  input  logic               eos_vld_i,
  input  logic [SRC_W-1:0]   eos_src_i,
  input  logic [7:0]         cpu_lvl_i,
  input  logic               claim_i,
  output logic               deliver_o,
  output logic [7:0]         hp_lvl_o,
  output logic [NUM_LVL-1:0] lvl_mask_o,
  output logic               claim_vld_o,
  output logic [SRC_W-1:0]   claim_src_o,
  output logic [7:0]         claim_lvl_o,
  output logic [VEC_W-1:0]   claim_vec_o
);
  import prio_irq_pkg::*;

  logic [NUM_SRC-1:0]            mode_q;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q, lvl_d;
  logic [NUM_SRC-1:0][VEC_W-1:0] vec_q;

  logic [NUM_SRC-1:0] pend_q, pend_d, insvc_q, insvc_d;
  logic [NUM_SRC-1:0] elig_q, elig_d;
  logic [NUM_SRC-1:0] raise_m, clr_m, eos_m, take_m, edge_take, lvl_take;
  logic [NUM_LVL-1:0] mask_q, mask_d;
  logic [7:0]         hp_q, hp_d;
  logic               pick_found, take;
  logic [SRC_W-1:0]   pick_idx;

  logic               rsp_vld_q;
  logic [SRC_W-1:0]   rsp_src_q;
  logic [7:0]         rsp_lvl_q;
  logic [VEC_W-1:0]   rsp_vec_q;

  prio_irq_cfg #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (cfg_we_i),
    .src_i      (cfg_src_i),
    .lvl_mode_i (cfg_lvl_mode_i),
    .lvl_i      (cfg_lvl_i),
    .vec_i      (cfg_vec_i),
    .mode_q     (mode_q),
    .lvl_q      (lvl_q),
    .lvl_d      (lvl_d),
    .vec_q      (vec_q)
  );

  // Current-state selection for claims
  assign elig_q    = pend_q & ~insvc_q;
  assign deliver_o = (hp_q != LVL_NONE) && (hp_q > cpu_lvl_i);

  prio_irq_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_pick (
    .elig_i    (elig_q),
    .lvl_i     (lvl_q),
    .sel_lvl_i (hp_q[LVL_W-1:0]),
    .found_o   (pick_found),
    .idx_o     (pick_idx)
  );

  assign take = claim_i && deliver_o && pick_found;

  // Next-state for pending and in-service vectors; clear has last word
  always_comb begin
    raise_m   = NUM_SRC'(raise_vld_i) << raise_src_i;
    clr_m     = NUM_SRC'(clr_vld_i)   << clr_src_i;
    eos_m     = NUM_SRC'(eos_vld_i)   << eos_src_i;
    take_m    = NUM_SRC'(take)        << pick_idx;
    edge_take = take_m & ~mode_q;
    lvl_take  = take_m & mode_q;
    pend_d    = ((pend_q & ~edge_take) | raise_m) & ~clr_m;
    insvc_d   = (insvc_q & ~eos_m) | lvl_take;
    elig_d    = pend_d & ~insvc_d;
  end

  prio_irq_summary #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_sum (
    .elig_i (elig_d),
    .lvl_i  (lvl_d),
    .mask_o (mask_d),
    .top_o  (hp_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      insvc_q <= '0;
      mask_q  <= '0;
      hp_q    <= LVL_NONE;
    end else begin
      pend_q  <= pend_d;
      insvc_q <= insvc_d;
      mask_q  <= mask_d;
      hp_q    <= hp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld_q <= 1'b0;
      rsp_src_q <= '0;
      rsp_lvl_q <= '0;
      rsp_vec_q <= '0;
    end else begin
      rsp_vld_q <= take;
      if (take) begin
        rsp_src_q <= pick_idx;
        rsp_lvl_q <= hp_q;
        rsp_vec_q <= vec_q[pick_idx];
      end
    end
  end

  assign hp_lvl_o    = hp_q;
  assign lvl_mask_o  = mask_q;
  assign claim_vld_o = rsp_vld_q;
  assign claim_src_o = rsp_src_q;
  assign claim_lvl_o = rsp_lvl_q;
  assign claim_vec_o = rsp_vec_q;
endmodule

// File: rtl/prio_irq_tracker_chk.sv
module prio_irq_tracker_chk #(
  parameter int NUM_LVL = 16,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               claim_i,
  input logic [7:0]         cpu_lvl_i,
  input logic               deliver_o,
  input logic [7:0]         hp_lvl_o,
  input logic [NUM_LVL-1:0] lvl_mask_o,
  input logic               claim_vld_o,
  input logic [7:0]         claim_lvl_o
);
  // R2: sentinel and summary mask agree
  p_sentinel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_lvl_o == 8'hFF) == (lvl_mask_o == '0));

  // R2: the reported highest level has its summary bit set
  p_top_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_lvl_o != 8'hFF) |-> lvl_mask_o[hp_lvl_o[LVL_W-1:0]]);

  // R3: delivery needs some eligible level
  p_deliver_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_o |-> (lvl_mask_o != '0));

  // R6: granted claim answers next cycle with the level that was on top
  p_claim_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_i && deliver_o) |=> (claim_vld_o && claim_lvl_o == $past(hp_lvl_o)));

  // R6: response level lies above the processor level at claim time
  p_claim_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_i && deliver_o) |=> (claim_lvl_o > $past(cpu_lvl_i)));

  // R10: no valid response without a deliverable claim
  p_claim_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(claim_i && deliver_o) |=> !claim_vld_o);
endmodule

bind prio_irq_tracker prio_irq_tracker_chk #(.NUM_LVL(NUM_LVL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .claim_i     (claim_i),
  .cpu_lvl_i   (cpu_lvl_i),
  .deliver_o   (deliver_o),
  .hp_lvl_o    (hp_lvl_o),
  .lvl_mask_o  (lvl_mask_o),
  .claim_vld_o (claim_vld_o),
  .claim_lvl_o (claim_lvl_o)
);

// File: tb/prio_irq_tracker_bench.sv
module prio_irq_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NL = 8;
  localparam int VW = 8;
  localparam int SW = $clog2(NS);
  localparam int LW = $clog2(NL);

  logic clk, rst_n;
  logic raise_vld_i, clr_vld_i, cfg_we_i, cfg_lvl_mode_i, eos_vld_i, claim_i;
  logic [SW-1:0] raise_src_i, clr_src_i, cfg_src_i, eos_src_i;
  logic [LW-1:0] cfg_lvl_i;
  logic [VW-1:0] cfg_vec_i;
  logic [7:0]    cpu_lvl_i;
  logic          deliver_o, claim_vld_o;
  logic [7:0]    hp_lvl_o, claim_lvl_o;
  logic [NL-1:0] lvl_mask_o;
  logic [SW-1:0] claim_src_o;
  logic [VW-1:0] claim_vec_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit m_pend [NS];
  bit m_insvc[NS];
  bit m_mode [NS];
  int m_lvl  [NS];
  int m_vec  [NS];

  prio_irq_tracker #(.NUM_SRC(NS), .NUM_LVL(NL), .VEC_W(VW)) u_prio_irq_tracker (
    .clk(clk), .rst_n(rst_n),
    .raise_vld_i(raise_vld_i), .raise_src_i(raise_src_i),
    .clr_vld_i(clr_vld_i), .clr_src_i(clr_src_i),
    .cfg_we_i(cfg_we_i), .cfg_src_i(cfg_src_i), .cfg_lvl_mode_i(cfg_lvl_mode_i),
    .cfg_lvl_i(cfg_lvl_i), .cfg_vec_i(cfg_vec_i),
    .eos_vld_i(eos_vld_i), .eos_src_i(eos_src_i),
    .cpu_lvl_i(cpu_lvl_i), .claim_i(claim_i),
    .deliver_o(deliver_o), .hp_lvl_o(hp_lvl_o), .lvl_mask_o(lvl_mask_o),
    .claim_vld_o(claim_vld_o), .claim_src_o(claim_src_o),
    .claim_lvl_o(claim_lvl_o), .claim_vec_o(claim_vec_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  function automatic int m_hp();
    int h = 255;
    for (int l = 0; l < NL; l++)
      for (int s = 0; s < NS; s++)
        if (m_pend[s] && !m_insvc[s] && m_lvl[s] == l) h = l;
    return h;
  endfunction

  function automatic logic [31:0] m_mask();
    logic [31:0] m = 0;
    for (int s = 0; s < NS; s++)
      if (m_pend[s] && !m_insvc[s]) m[m_lvl[s]] = 1'b1;
    return m;
  endfunction

  // one clock edge, returning at the following falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    raise_vld_i = 0; clr_vld_i = 0; cfg_we_i = 0; eos_vld_i = 0; claim_i = 0;
  endtask

  task automatic check_state(string tag);
    check({tag, " hp"}, {24'd0, hp_lvl_o}, m_hp());
    check({tag, " mask"}, {24'd0, lvl_mask_o}, m_mask());
  endtask

  // R3: sweep the processor level against the current state
  task automatic sweep_deliver();
    int h = m_hp();
    for (int c = 0; c <= NL; c++) begin
      cpu_lvl_i = 8'(c);
      #1;
      check("R3 deliver", {31'd0, deliver_o}, (h != 255 && h > c) ? 1 : 0);
    end
    cpu_lvl_i = 0;
    @(negedge clk);
  endtask

  task automatic do_cfg(int s, bit mode, int lvl, int vec);
    cfg_we_i = 1; cfg_src_i = SW'(s); cfg_lvl_mode_i = mode;
    cfg_lvl_i = LW'(lvl); cfg_vec_i = VW'(vec);
    cyc();
    cfg_we_i = 0;
    m_mode[s] = mode; m_lvl[s] = lvl; m_vec[s] = vec;
  endtask

  task automatic do_raise(int s);
    raise_vld_i = 1; raise_src_i = SW'(s);
    cyc();
    raise_vld_i = 0;
    m_pend[s] = 1;
  endtask

  task automatic do_clear(int s);
    clr_vld_i = 1; clr_src_i = SW'(s);
    cyc();
    clr_vld_i = 0;
    m_pend[s] = 0;
  endtask

  task automatic do_eos(int s);
    eos_vld_i = 1; eos_src_i = SW'(s);
    cyc();
    eos_vld_i = 0;
    m_insvc[s] = 0;
  endtask

  // R6/R7/R8/R10: claim with expected result computed from the model
  task automatic do_claim(int cpu, output bit granted);
    int h = m_hp();
    int win = -1;
    granted = (h != 255 && h > cpu);
    if (granted)
      for (int s = NS - 1; s >= 0; s--)
        if (m_pend[s] && !m_insvc[s] && m_lvl[s] == h) win = s;
    cpu_lvl_i = 8'(cpu);
    claim_i = 1;
    cyc();
    claim_i = 0;
    check(granted ? "R6 claim valid" : "R10 claim refused", {31'd0, claim_vld_o}, granted ? 1 : 0);
    if (granted) begin
      check("R6 claim src", {29'd0, claim_src_o}, win);
      check("R6 claim lvl", {24'd0, claim_lvl_o}, h);
      check("R6 claim vec", {24'd0, claim_vec_o}, m_vec[win]);
      if (m_mode[win]) m_insvc[win] = 1;
      else             m_pend[win]  = 0;
    end
    check_state(granted ? "R7 R8 after claim" : "R10 no change");
    cpu_lvl_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit g;
    rst_n = 0;
    idle_inputs();
    raise_src_i = 0; clr_src_i = 0; cfg_src_i = 0; eos_src_i = 0;
    cfg_lvl_mode_i = 0; cfg_lvl_i = 0; cfg_vec_i = 0; cpu_lvl_i = 0;
    for (int s = 0; s < NS; s++) begin
      m_pend[s] = 0; m_insvc[s] = 0; m_mode[s] = 0; m_lvl[s] = 0; m_vec[s] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1
    check("R1 hp", {24'd0, hp_lvl_o}, 8'hFF);
    check("R1 mask", {24'd0, lvl_mask_o}, 0);
    check("R1 deliver", {31'd0, deliver_o}, 0);
    check("R1 claim_vld", {31'd0, claim_vld_o}, 0);
    @(negedge clk);

    // R11: levels 0,5,4,3,2,1,0,5; level mode on sources 0,3,6
    for (int s = 0; s < NS; s++)
      do_cfg(s, (s % 3) == 0, (s * 5) % 6, 8'h80 + s * 7);
    check_state("R11 config idle");

    // R2/R4: each source alone
    for (int s = 0; s < NS; s++) begin
      do_raise(s);
      check_state("R2 single raise");
      sweep_deliver();
      do_clear(s);
      check_state("R4 single clear");
    end

    // R2/R4: every pair
    for (int a = 0; a < NS; a++)
      for (int b = a + 1; b < NS; b++) begin
        do_raise(a);
        do_raise(b);
        check_state("R2 pair raise");
        do_clear(a);
        check_state("R4 pair clear first");
        do_clear(b);
        check_state("R4 pair clear second");
      end

    // R5: raise and clear on the same source, idle and already pending
    for (int s = 0; s < NS; s++) begin
      raise_vld_i = 1; raise_src_i = SW'(s);
      clr_vld_i = 1;   clr_src_i   = SW'(s);
      cyc();
      idle_inputs();
      check_state("R5 clear wins idle");
      do_raise(s);
      raise_vld_i = 1; clr_vld_i = 1;
      cyc();
      idle_inputs();
      m_pend[s] = 0;
      check_state("R5 clear wins pending");
    end

    // R6-R10: drain everything at each processor threshold
    for (int c = 0; c < NL; c++) begin
      for (int s = 0; s < NS; s++) do_raise(s);
      check_state("R2 all raised");
      g = 1;
      while (g) do_claim(c, g);
      for (int s = 0; s < NS; s++) begin
        if (m_insvc[s]) begin
          do_eos(s);
          check_state("R9 eos returns source");
        end
      end
      for (int s = 0; s < NS; s++) do_clear(s);
      check_state("R4 all cleared");
    end

    // R8/R9: level source 3 at level 3
    do_raise(3);
    do_claim(0, g);
    check("R8 level src in service", {24'd0, hp_lvl_o}, 8'hFF);
    do_claim(0, g);
    check("R10 in-service not granted", {31'd0, claim_vld_o}, 0);
    do_eos(3);
    check("R9 claimable again", {24'd0, hp_lvl_o}, 3);
    do_claim(0, g);
    do_clear(3);
    do_eos(3);
    check_state("R9 eos after clear");

    // R11: move a pending source to another level
    do_raise(2);
    check_state("R11 before move");
    do_cfg(2, 0, 7, 8'h5A);
    check_state("R11 after move");
    do_claim(0, g);
    check("R11 moved vector", {24'd0, claim_vec_o}, 8'h5A);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule